// File: doc/BRIEF.md
# Button-stepped PWM contrast generator

This block drives a single pin with a fixed-frequency pulse-width-modulated wave. An external RC filter turns that wave into the bias voltage that sets the contrast of a character display. Two active-low push buttons trim the setting. One raises the duty cycle and the other lowers it. The buttons are not edge-detected. They are read once per slow poll interval, and while a button is held the duty moves one step per poll. The result is a steady auto-repeat with no extra debounce logic.

The PWM period is `PERIOD_STEPS` steps long. Each step lasts `CLK_PER_STEP` clock cycles, which gives 20 steps of 1 us (50 kHz) with the defaults at 125 MHz. Within each period the pin stays low first. It goes high at the compare point and returns low when the period wraps, so it is high for exactly `duty` steps. The requested duty is copied into the waveform only when a period starts, so no period is ever cut short or stretched. The requested duty always stays between `DUTY_MIN` and `DUTY_MAX`, and after reset it is `DUTY_INIT`.

Top module: `contrast_pwm_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `duty_o` equals `DUTY_INIT` (10) and `pwm_o` is low.
- R2: A PWM period is `PERIOD_STEPS` steps of `CLK_PER_STEP` clocks each. The step counter runs from 0 to `PERIOD_STEPS`-1. `pwm_o` is high exactly while the counter is at or above `PERIOD_STEPS` minus the active duty, so it falls only when the counter wraps to 0.
- R3: The active duty that shapes the wave is loaded from `duty_o` only on the clock where the step counter wraps to 0. Every high pulse therefore lasts exactly active-duty × `CLK_PER_STEP` clocks.
- R4: When the synchronised raise button (`btn_up_ni` low) is seen on a poll tick, `duty_o` rises by 1 unless it already equals `DUTY_MAX` (19). `duty_o` never changes by more than 1 per clock.
- R5: When only the synchronised lower button (`btn_dn_ni` low) is seen on a poll tick, `duty_o` falls by 1 unless it already equals `DUTY_MIN` (3).
- R6: When both buttons are seen held on a poll tick, the raise wins and the lower request is discarded for that tick.
- R7: Each button passes through two flip-flops and is sampled only on the poll tick, which comes every `POLL_STEPS` steps. A press that starts and ends between two poll ticks leaves `duty_o` unchanged.
- R8: `duty_o` stays within `DUTY_MIN`..`DUTY_MAX` inclusive at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| btn_up_ni | input | 1 | Raise button, active low, asynchronous |
| btn_dn_ni | input | 1 | Lower button, active low, asynchronous |
| pwm_o | output | 1 | PWM output to the contrast filter |
| duty_o | output | $clog2(PERIOD_STEPS+1) | Requested duty in steps per period |

## Verification
The bench builds the block with `CLK_PER_STEP` = 2 and `POLL_STEPS` = 30, keeping the 20-step period and the 3/19/10 limits. This shrinks the 50 ms poll to 60 clocks. Full sweeps into both clamps, the exact count of polls a held button yields, and the both-held priority all fit in a few thousand cycles. The small prescaler still leaves each step two clocks wide, so a duty change that lands in the middle of a period can be seen to wait for the wrap.

// File: rtl/contrast_pkg.sv
package contrast_pkg;

    // Index of each button inside the packed button vectors
    localparam int unsigned BTN_UP  = 0;
    localparam int unsigned BTN_DN  = 1;
    localparam int unsigned NUM_BTN = 2;

    // Adjustment decided on a poll tick
    typedef enum logic [1:0] {
        ADJ_KEEP  = 2'd0,
        ADJ_RAISE = 2'd1,
        ADJ_LOWER = 2'd2
    } adj_e;

endpackage

// File: rtl/contrast_btn_sync.sv
module contrast_btn_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] btn_ni,
    output logic [WIDTH-1:0] held_o
);

    // Two-stage synchroniser per button; reset value is "released" (high)
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = btn_ni;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.meta <= {WIDTH{1'b1}};
            st_q.stab <= {WIDTH{1'b1}};
        end else begin
            st_q <= st_d;
        end
    end

    // Active-high "held" view of the synchronised levels
    assign held_o = ~st_q.stab;

endmodule

// File: rtl/contrast_timebase.sv
module contrast_timebase #(
    parameter int unsigned CLK_PER_STEP = 125,
    parameter int unsigned POLL_STEPS   = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic step_tick_o,
    output logic poll_tick_o
);

    localparam int unsigned PRE_W  = (CLK_PER_STEP > 1) ? $clog2(CLK_PER_STEP) : 1;
    localparam int unsigned POLL_W = (POLL_STEPS > 1)   ? $clog2(POLL_STEPS)   : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLK_PER_STEP - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_STEPS - 1);

    // Step prescaler: one pulse every CLK_PER_STEP clocks
    if (CLK_PER_STEP > 1) begin : g_prescale
        logic [PRE_W-1:0] pre_d, pre_q;

        always_comb begin
            pre_d = pre_q;
            if (pre_q == PRE_LAST) pre_d = '0;
            else                   pre_d = pre_q + PRE_W'(1);
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) pre_q <= '0;
            else         pre_q <= pre_d;
        end

        assign step_tick_o = (pre_q == PRE_LAST);
    end else begin : g_no_prescale
        assign step_tick_o = 1'b1;
    end

    // Poll divider: one pulse every POLL_STEPS steps
    if (POLL_STEPS > 1) begin : g_poll_div
        logic [POLL_W-1:0] poll_d, poll_q;

        always_comb begin
            poll_d = poll_q;
            if (step_tick_o) begin
                if (poll_q == POLL_LAST) poll_d = '0;
                else                     poll_d = poll_q + POLL_W'(1);
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) poll_q <= '0;
            else         poll_q <= poll_d;
        end

        assign poll_tick_o = step_tick_o && (poll_q == POLL_LAST);
    end else begin : g_poll_every_step
        assign poll_tick_o = step_tick_o;
    end

endmodule

// File: rtl/contrast_duty_ctl.sv
module contrast_duty_ctl
    import contrast_pkg::*;
#(
    parameter int unsigned DUTY_W    = 5,
    parameter int unsigned DUTY_MIN  = 3,
    parameter int unsigned DUTY_MAX  = 19,
    parameter int unsigned DUTY_INIT = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              poll_tick_i,
    input  logic              held_up_i,
    input  logic              held_dn_i,
    output logic [DUTY_W-1:0] duty_o
);

    localparam logic [DUTY_W-1:0] LIM_LO = DUTY_W'(DUTY_MIN);
    localparam logic [DUTY_W-1:0] LIM_HI = DUTY_W'(DUTY_MAX);
    localparam logic [DUTY_W-1:0] START  = DUTY_W'(DUTY_INIT);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } duty_st_t;

    duty_st_t st_d, st_q;
    adj_e     adj;

    // Raise is examined first; lower only when raise is not held
    always_comb begin
        adj = ADJ_KEEP;
        if (held_up_i)      adj = ADJ_RAISE;
        else if (held_dn_i) adj = ADJ_LOWER;
    end

    always_comb begin
        st_d = st_q;
        if (poll_tick_i) begin
            unique case (adj)
                ADJ_RAISE: if (st_q.duty < LIM_HI) st_d.duty = st_q.duty + DUTY_W'(1);
                ADJ_LOWER: if (st_q.duty > LIM_LO) st_d.duty = st_q.duty - DUTY_W'(1);
                default:   st_d.duty = st_q.duty;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.duty <= START;
        else         st_q      <= st_d;
    end

    assign duty_o = st_q.duty;

endmodule

// File: rtl/contrast_pwm_core.sv
module contrast_pwm_core #(
    parameter int unsigned PERIOD_STEPS = 20,
    parameter int unsigned DUTY_W       = 5,
    parameter int unsigned DUTY_INIT    = 10
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            step_tick_i,
    input  logic [DUTY_W-1:0]               duty_i,
    output logic                            pwm_o,
    output logic [$clog2(PERIOD_STEPS)-1:0] step_cnt_o,
    output logic [DUTY_W-1:0]               act_duty_o
);

    localparam int unsigned       CNT_W    = $clog2(PERIOD_STEPS);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PERIOD_STEPS - 1);
    localparam logic [DUTY_W-1:0] PER_D    = DUTY_W'(PERIOD_STEPS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DUTY_W-1:0] act;
    } pwm_st_t;

    pwm_st_t st_d, st_q;
    logic    wrap;
    logic [DUTY_W-1:0] thresh;

    assign wrap = step_tick_i && (st_q.cnt == CNT_LAST);

    always_comb begin
        st_d = st_q;
        if (step_tick_i) begin
            if (wrap) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        // New duty is taken only as a fresh period begins
        if (wrap) st_d.act = duty_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.act <= DUTY_W'(DUTY_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    // Low first, high for the last act steps, falling at the wrap
    assign thresh     = PER_D - st_q.act;
    assign pwm_o      = (DUTY_W'(st_q.cnt) >= thresh);
    assign step_cnt_o = st_q.cnt;
    assign act_duty_o = st_q.act;

endmodule

// File: rtl/contrast_pwm_gen.sv
module contrast_pwm_gen
    import contrast_pkg::*;
#(
    parameter int unsigned CLK_PER_STEP = 125,
    parameter int unsigned PERIOD_STEPS = 20,
    parameter int unsigned POLL_STEPS   = 50000,
    parameter int unsigned DUTY_MIN     = 3,
    parameter int unsigned DUTY_MAX     = 19,
    parameter int unsigned DUTY_INIT    = 10
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              btn_up_ni,
    input  logic                              btn_dn_ni,
    output logic                              pwm_o,
    output logic [$clog2(PERIOD_STEPS+1)-1:0] duty_o
);

    localparam int unsigned DUTY_W = $clog2(PERIOD_STEPS + 1);
    localparam int unsigned CNT_W  = $clog2(PERIOD_STEPS);

    logic [NUM_BTN-1:0] btn_n;
    logic [NUM_BTN-1:0] held;
    logic               held_up;
    logic               held_dn;
    logic               step_tick;
    logic               poll_tick;
    logic [CNT_W-1:0]   step_cnt;
    logic [DUTY_W-1:0]  act_duty;
    logic [DUTY_W-1:0]  duty_req;

    assign btn_n[BTN_UP] = btn_up_ni;
    assign btn_n[BTN_DN] = btn_dn_ni;
    assign held_up       = held[BTN_UP];
    assign held_dn       = held[BTN_DN];

    contrast_btn_sync #(
        .WIDTH (NUM_BTN)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .btn_ni (btn_n),
        .held_o (held)
    );

    contrast_timebase #(
        .CLK_PER_STEP (CLK_PER_STEP),
        .POLL_STEPS   (POLL_STEPS)
    ) u_timebase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_tick_o (step_tick),
        .poll_tick_o (poll_tick)
    );

    contrast_duty_ctl #(
        .DUTY_W    (DUTY_W),
        .DUTY_MIN  (DUTY_MIN),
        .DUTY_MAX  (DUTY_MAX),
        .DUTY_INIT (DUTY_INIT)
    ) u_duty (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .poll_tick_i (poll_tick),
        .held_up_i   (held_up),
        .held_dn_i   (held_dn),
        .duty_o      (duty_req)
    );

    contrast_pwm_core #(
        .PERIOD_STEPS (PERIOD_STEPS),
        .DUTY_W       (DUTY_W),
        .DUTY_INIT    (DUTY_INIT)
    ) u_pwm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_tick_i (step_tick),
        .duty_i      (duty_req),
        .pwm_o       (pwm_o),
        .step_cnt_o  (step_cnt),
        .act_duty_o  (act_duty)
    );

    assign duty_o = duty_req;

endmodule

// File: rtl/contrast_pwm_chk.sv
module contrast_pwm_chk #(
    parameter int unsigned PERIOD_STEPS = 20,
    parameter int unsigned DUTY_W       = 5,
    parameter int unsigned DUTY_MIN     = 3,
    parameter int unsigned DUTY_MAX     = 19
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic                            pwm_o,
    input logic [DUTY_W-1:0]               duty_o,
    input logic [$clog2(PERIOD_STEPS)-1:0] step_cnt,
    input logic [DUTY_W-1:0]               act_duty,
    input logic                            held_up,
    input logic                            held_dn
);

    assert_duty_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_o >= DUTY_W'(DUTY_MIN)) && (duty_o <= DUTY_W'(DUTY_MAX)));

    assert_act_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_duty >= DUTY_W'(DUTY_MIN)) && (act_duty <= DUTY_W'(DUTY_MAX)));

    assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_o != $past(duty_o)) |->
            ((duty_o == $past(duty_o) + DUTY_W'(1)) || (duty_o + DUTY_W'(1) == $past(duty_o))));

    assert_raise_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(held_up) |-> (duty_o >= $past(duty_o)));

    assert_idle_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(held_up) && !$past(held_dn)) |-> $stable(duty_o));

    assert_act_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((step_cnt != '0) || ($past(step_cnt) == '0)) |-> $stable(act_duty));

    assert_fall_at_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pwm_o) |-> (step_cnt == '0));

endmodule

bind contrast_pwm_gen contrast_pwm_chk #(
    .PERIOD_STEPS (PERIOD_STEPS),
    .DUTY_W       (DUTY_W),
    .DUTY_MIN     (DUTY_MIN),
    .DUTY_MAX     (DUTY_MAX)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_o    (pwm_o),
    .duty_o   (duty_o),
    .step_cnt (step_cnt),
    .act_duty (act_duty),
    .held_up  (held_up),
    .held_dn  (held_dn)
);

// File: tb/tb_contrast_pwm_gen.sv
module tb_contrast_pwm_gen;

    localparam int CPS  = 2;
    localparam int PER  = 20;
    localparam int PS   = 30;
    localparam int MIN  = 3;
    localparam int MAX  = 19;
    localparam int INIT = 10;
    localparam int DW   = $clog2(PER + 1);
    localparam int POLL_CLK = CPS * PS;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_n  = 1'b1;
    logic          dn_n  = 1'b1;
    logic          pwm;
    logic [DW-1:0] duty;

    always #4 clk = ~clk;

    contrast_pwm_gen #(
        .CLK_PER_STEP (CPS),
        .PERIOD_STEPS (PER),
        .POLL_STEPS   (PS),
        .DUTY_MIN     (MIN),
        .DUTY_MAX     (MAX),
        .DUTY_INIT    (INIT)
    ) dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .btn_up_ni (up_n),
        .btn_dn_ni (dn_n),
        .pwm_o     (pwm),
        .duty_o    (duty)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference: counters as integers, synchroniser as a queue
    int       m_pre, m_poll, m_cnt, m_act, m_duty;
    bit [1:0] sq[$];   // bit0 raise, bit1 lower (raw active-low levels)

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_poll = 0; m_cnt = 0;
            m_act = INIT; m_duty = INIT;
            sq = '{2'b11, 2'b11};
        end else begin
            bit [1:0] s2;
            bit st, pl, wr;
            s2 = sq[0];
            st = (m_pre == CPS - 1);
            pl = st && (m_poll == PS - 1);
            wr = st && (m_cnt == PER - 1);
            if (wr) m_act = m_duty;
            if (pl) begin
                if (!s2[0]) begin
                    if (m_duty < MAX) m_duty++;
                end else if (!s2[1]) begin
                    if (m_duty > MIN) m_duty--;
                end
            end
            m_pre = st ? 0 : m_pre + 1;
            if (st) begin
                m_poll = pl ? 0 : m_poll + 1;
                m_cnt  = wr ? 0 : m_cnt + 1;
            end
            void'(sq.pop_front());
            sq.push_back({dn_n, up_n});
        end
    end

    // Per-clock comparison and high-pulse length measurement
    int run = 0;
    int act_at_rise = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", int'(pwm), (m_cnt >= PER - m_act) ? 1 : 0, "pwm level");
            check("R4", int'(duty), m_duty, "duty value");
            check("R8", (int'(duty) >= MIN && int'(duty) <= MAX) ? 1 : 0, 1, "duty range");
            if (pwm) begin
                if (run == 0) act_at_rise = m_act;
                run++;
            end else if (run > 0) begin
                check("R3", run, act_at_rise * CPS, "high pulse clocks");
                run = 0;
            end
        end
    end

    initial begin
        int d0;
        wait_clk(4);
        check("R1", int'(duty), INIT, "duty in reset");
        check("R1", int'(pwm), 0, "pwm in reset");
        rst_n = 1'b1;
        wait_clk(1);
        check("R1", int'(duty), INIT, "duty after reset");
        check("R1", int'(pwm), 0, "pwm after reset");

        // Two untouched periods at the reset duty
        wait_clk(2 * PER * CPS);
        check("R2", int'(duty), INIT, "duty idle");

        // Hold raise well past the top limit
        up_n = 1'b0;
        wait_clk(12 * POLL_CLK);
        up_n = 1'b1;
        wait_clk(3);
        check("R4", int'(duty), MAX, "clamped at top");

        // Hold lower well past the bottom limit
        dn_n = 1'b0;
        wait_clk(20 * POLL_CLK);
        dn_n = 1'b1;
        wait_clk(3);
        check("R5", int'(duty), MIN, "clamped at bottom");

        // Exactly five polls of raise
        up_n = 1'b0;
        wait_clk(5 * POLL_CLK);
        up_n = 1'b1;
        wait_clk(3);
        check("R4", int'(duty), MIN + 5, "five raise polls");

        // Both held for four polls: raise must win every time
        up_n = 1'b0;
        dn_n = 1'b0;
        wait_clk(4 * POLL_CLK);
        up_n = 1'b1;
        dn_n = 1'b1;
        wait_clk(3);
        check("R6", int'(duty), MIN + 9, "both held");

        // Short lower pulse that never reaches a poll sample
        while (!(m_poll == 3 && m_pre == 0)) @(negedge clk);
        d0 = int'(duty);
        dn_n = 1'b0;
        wait_clk(4);
        dn_n = 1'b1;
        wait_clk(2 * POLL_CLK);
        check("R7", int'(duty), d0, "pulse between polls");

        // Let a few more periods run at the final duty
        wait_clk(3 * PER * CPS);
        check("R3", int'(duty), MIN + 9, "final duty");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule